// File: doc/BRIEF.md
# Vector Operand Remap Selector

This block sits in the operand path of a vector pipeline. For every register operand of an operation it decides whether that operand's element index runs linearly or through one of three shape remappers. One control word names up to three physical registers and ties each one to a shape. An operand whose physical register number equals an enabled entry takes its element offset from that shape's remapper output. Any other operand keeps its linear element index. The block then adds the operand's base register to the chosen offset and flags an overrun when the sum falls outside the register file.

The control word and three shape words are loaded through a single-cycle write port. The shape words are handed to the remappers as they are. The remapper arithmetic and the execution units lie outside this block. Every operand is resolved independently in the same cycle. Two predicated operands, or three operands of a single operation, can therefore each be remapped through a different shape at once.

Top module: `opnd_remap_sel`

## Requirements
- R1: After reset no entry is enabled: every operand reports remapped=0, offset equal to its linear index, physical number equal to base plus linear index, cfg_bad low and all shape words zero.
- R2: A control word write (cfg_sel=0) places entry e's register number in bits 8e+6..8e and its shape select in bits 25+2e..24+2e. An operand whose register equals an enabled entry takes its offset from remapper input rm_idx slot s, where s is that entry's shape select.
- R3: A control word write with any of bits 7, 15, 23, 30 or 31 set raises cfg_rej in that cycle. The write is discarded and operand resolution keeps the previous configuration.
- R4: An entry whose register field is zero is disabled. An operand with register 0 is never remapped.
- R5: A shape select of 3 on an enabled entry raises cfg_bad. An operand matching that entry is not remapped and uses its linear index.
- R6: When several entries name the same register, the lowest-numbered entry decides the shape.
- R7: All three operands are resolved independently in the same cycle, and each may use a different shape.
- R8: out_ovr for an operand is high exactly when its op_vld bit is set and base plus offset is at least RF_REGS (128 by default).
- R9: A write becomes visible one clock edge after it is presented. In the cycle the write is presented, outputs still follow the old configuration.
- R10: Writes with cfg_sel 1, 2 and 3 load shape words 0, 1 and 2. These are presented on shape_words at bits 32k+31..32k, and no reserved-bit rejection applies to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 selects the control word; 1 to 3 select shape words 0 to 2 |
| cfg_wdata | input | 32 | Write data |
| cfg_rej | output | 1 | Control word write rejected (reserved bit set) |
| cfg_bad | output | 1 | An enabled entry selects reserved shape 3 |
| shape_words | output | 96 | Shape words 2,1,0 packed high to low |
| op_vld | input | NOPS | Operand valid, one bit per operand |
| op_reg | input | NOPS*7 | Operand base physical register numbers |
| op_lin | input | NOPS*IDXW | Linear element index per operand |
| rm_idx | input | 3*IDXW | Remapped index from each shape's remapper |
| out_phys | output | NOPS*SW | Base plus selected offset, SW = max(7,IDXW)+1 |
| out_off | output | NOPS*IDXW | Selected element offset per operand |
| out_rm | output | NOPS | Operand was remapped |
| out_ovr | output | NOPS | Register file overrun trap per operand |

## Verification
The hardest case to reach from the ports is two or three entries naming the same register while a different register is also mapped. Only that combination separates lowest-entry priority from simple matching. The stimulus table therefore holds control words with duplicated and crossed entries, and it reuses one operand set so that each vector changes only the mapping. Directed steps place the overrun exactly at the last register and one past it. They also probe the write-timing window by sampling while a write is still pending.

// File: rtl/opnd_remap_sel.sv
module opnd_remap_sel #(
  parameter int IDXW    = 7,
  parameter int NOPS    = 3,
  parameter int RF_REGS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [31:0]          cfg_wdata,
  output logic                 cfg_rej,
  output logic                 cfg_bad,
  output logic [95:0]          shape_words,
  input  logic [NOPS-1:0]      op_vld,
  input  logic [NOPS*7-1:0]    op_reg,
  input  logic [NOPS*IDXW-1:0] op_lin,
  input  logic [3*IDXW-1:0]    rm_idx,
  output logic [NOPS*((7>IDXW?7:IDXW)+1)-1:0] out_phys,
  output logic [NOPS*IDXW-1:0] out_off,
  output logic [NOPS-1:0]      out_rm,
  output logic [NOPS-1:0]      out_ovr
);
  localparam int REGW = 7;
  localparam int NENT = 3;
  localparam int SW   = (REGW > IDXW ? REGW : IDXW) + 1;

  logic [REGW-1:0] ent_reg [NENT];
  logic [1:0]      ent_sh  [NENT];
  logic [31:0]     shp     [NENT];
  logic [NENT-1:0] ent_on;

  wire rsvd = cfg_wdata[7] | cfg_wdata[15] | cfg_wdata[23] | (|cfg_wdata[31:30]);
  assign cfg_rej = cfg_we && cfg_sel == 2'd0 && rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) begin
        ent_reg[e] <= '0;
        ent_sh[e]  <= '0;
        shp[e]     <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_sel == 2'd0) begin
        if (!rsvd)
          for (int e = 0; e < NENT; e++) begin
            ent_reg[e] <= cfg_wdata[8*e +: REGW];
            ent_sh[e]  <= cfg_wdata[24+2*e +: 2];
          end
      end else begin
        shp[cfg_sel-2'd1] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    cfg_bad = 1'b0;
    for (int e = 0; e < NENT; e++) begin
      ent_on[e] = ent_reg[e] != '0;
      if (ent_on[e] && ent_sh[e] == 2'd3) cfg_bad = 1'b1;
    end
  end

  assign shape_words = {shp[2], shp[1], shp[0]};

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    logic [REGW-1:0] base;
    logic [IDXW-1:0] lin, off;
    logic [1:0]      sh;
    logic            hit, use_rm;
    logic [SW-1:0]   phys;

    assign base = op_reg[k*REGW +: REGW];
    assign lin  = op_lin[k*IDXW +: IDXW];

    always_comb begin
      hit = 1'b0;
      sh  = 2'd0;
      for (int e = NENT-1; e >= 0; e--)
        if (ent_on[e] && ent_reg[e] == base) begin
          hit = 1'b1;
          sh  = ent_sh[e];
        end
    end

    assign use_rm = hit && sh != 2'd3;

    always_comb begin
      case (sh)
        2'd0:    off = rm_idx[0 +: IDXW];
        2'd1:    off = rm_idx[IDXW +: IDXW];
        2'd2:    off = rm_idx[2*IDXW +: IDXW];
        default: off = lin;
      endcase
      if (!use_rm) off = lin;
    end

    assign phys = SW'(base) + SW'(off);

    assign out_off[k*IDXW +: IDXW] = off;
    assign out_phys[k*SW +: SW]    = phys;
    assign out_rm[k]               = use_rm;
    assign out_ovr[k]              = op_vld[k] && (phys >= SW'(RF_REGS));
  end
endmodule

// File: rtl/remap_sel_chk.sv
module remap_sel_chk #(
  parameter int IDXW    = 7,
  parameter int NOPS    = 3,
  parameter int RF_REGS = 128,
  parameter int SW      = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_rej,
  input logic [26:0]          ent_bits,
  input logic [NOPS-1:0]      op_vld,
  input logic [NOPS*7-1:0]    op_reg,
  input logic [NOPS*IDXW-1:0] op_lin,
  input logic [NOPS*SW-1:0]   out_phys,
  input logic [NOPS*IDXW-1:0] out_off,
  input logic [NOPS-1:0]      out_rm,
  input logic [NOPS-1:0]      out_ovr
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rej |=> $stable(ent_bits));

  for (genvar k = 0; k < NOPS; k++) begin : g_k
    p_linear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_rm[k] |-> out_off[k*IDXW +: IDXW] == op_lin[k*IDXW +: IDXW]);
    p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      op_reg[k*7 +: 7] == 7'd0 |-> !out_rm[k]);
    p_trap_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovr[k] |-> op_vld[k]);
    p_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op_vld[k] && !out_ovr[k] |-> out_phys[k*SW +: SW] < SW'(RF_REGS));
  end
endmodule

bind opnd_remap_sel remap_sel_chk #(
  .IDXW(IDXW), .NOPS(NOPS), .RF_REGS(RF_REGS), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rej(cfg_rej),
  .ent_bits({ent_sh[2], ent_sh[1], ent_sh[0], ent_reg[2], ent_reg[1], ent_reg[0]}),
  .op_vld(op_vld), .op_reg(op_reg), .op_lin(op_lin),
  .out_phys(out_phys), .out_off(out_off), .out_rm(out_rm), .out_ovr(out_ovr)
);

// File: tb/sim_opnd_remap_sel.sv
`timescale 1ns/1ps
module sim_opnd_remap_sel;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        cfg_rej, cfg_bad;
  logic [95:0] shape_words;
  logic [2:0]  op_vld = 3'b111;
  logic [20:0] op_reg = 0, op_lin = 0, rm_idx = 0;
  logic [23:0] out_phys;
  logic [20:0] out_off;
  logic [2:0]  out_rm, out_ovr;

  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opnd_remap_sel u0 (.*);

  function automatic logic [31:0] mk(logic [6:0] r0, logic [1:0] s0,
                                     logic [6:0] r1, logic [1:0] s1,
                                     logic [6:0] r2, logic [1:0] s2);
    return {2'b0, s2, s1, s0, 1'b0, r2, 1'b0, r1, 1'b0, r0};
  endfunction

  typedef struct packed {
    logic [31:0] ctrl;
    logic [20:0] regs;
    logic [23:0] phys;
    logic [2:0]  rm;
    logic        bad;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{32'd0,                   {7'd40,7'd16,7'd8}, {8'd43,8'd18,8'd9},  3'b000, 1'b0},
    '{mk(8,0,16,1,40,2),       {7'd40,7'd16,7'd8}, {8'd60,8'd25,8'd13}, 3'b111, 1'b0},
    '{mk(16,2,8,1,0,0),        {7'd40,7'd16,7'd8}, {8'd43,8'd36,8'd17}, 3'b011, 1'b0},
    '{mk(8,2,8,0,0,0),         {7'd40,7'd16,7'd8}, {8'd43,8'd18,8'd28}, 3'b001, 1'b0},
    '{mk(0,1,0,1,0,1),         {7'd40,7'd16,7'd0}, {8'd43,8'd18,8'd1},  3'b000, 1'b0},
    '{mk(8,3,16,0,0,0),        {7'd40,7'd16,7'd8}, {8'd43,8'd21,8'd9},  3'b010, 1'b1}
  };

  task automatic chk(bit ok, string req, logic [95:0] act, logic [95:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    nvec++; nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    op_reg = {7'd40,7'd16,7'd8};
    op_lin = {7'd3,7'd2,7'd1};
    rm_idx = {7'd20,7'd9,7'd5};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(out_phys == {8'd43,8'd18,8'd9}, "R1", out_phys, {8'd43,8'd18,8'd9});
    chk(out_rm == 0 && out_off == op_lin, "R1", {out_rm, out_off}, {3'b0, op_lin});
    chk(cfg_bad == 0, "R1", cfg_bad, 0);
    chk(shape_words == 0, "R1", shape_words, 0);

    // table: R2 fields, R4 zero, R5 shape 3, R6 priority, R7 independence
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, VT[i].ctrl);
      op_reg = VT[i].regs;
      @(negedge clk);
      chk(out_phys == VT[i].phys, $sformatf("R2/R7 vec%0d", i), out_phys, VT[i].phys);
      chk(out_rm == VT[i].rm, $sformatf("R6/R4 vec%0d", i), out_rm, VT[i].rm);
      chk(cfg_bad == VT[i].bad, $sformatf("R5 vec%0d", i), cfg_bad, VT[i].bad);
    end

    // R9: old config still in force while write is pending
    op_reg = {7'd40,7'd16,7'd8};
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_wdata = mk(16,1,0,0,0,0);
    #1;
    chk(out_phys[15:8] == 8'd21, "R9 before", out_phys[15:8], 21);
    chk(cfg_rej == 0, "R3 clean write", cfg_rej, 0);
    @(posedge clk); #1 cfg_we = 0;
    @(negedge clk);
    chk(out_phys[15:8] == 8'd25, "R9 after", out_phys[15:8], 25);

    // R3: reserved bits reject the write
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_wdata = mk(8,0,0,0,0,0) | 32'h8000_0000;
    #1 chk(cfg_rej == 1, "R3 bit31", cfg_rej, 1);
    @(posedge clk); #1 cfg_we = 0;
    @(negedge clk);
    chk(out_rm == 3'b010 && out_phys[7:0] == 8'd9, "R3 bit31 held", {out_rm, out_phys[7:0]}, {3'b010, 8'd9});
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_wdata = mk(8,0,0,0,0,0) | 32'h0000_0080;
    #1 chk(cfg_rej == 1, "R3 bit7", cfg_rej, 1);
    @(posedge clk); #1 cfg_we = 0;
    @(negedge clk);
    chk(out_rm == 3'b010, "R3 bit7 held", out_rm, 3'b010);

    // R10: shape words
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3; cfg_wdata = 32'hCAFE_8081;
    #1 chk(cfg_rej == 0, "R10 no reject", cfg_rej, 0);
    @(posedge clk); #1 cfg_we = 0;
    wr(2'd1, 32'h1234_5678);
    @(negedge clk);
    chk(shape_words == {32'hCAFE_8081, 32'h0, 32'h1234_5678}, "R10",
        shape_words, {32'hCAFE_8081, 32'h0, 32'h1234_5678});

    // R8: overrun boundary
    wr(2'd0, mk(100,0,0,0,0,0));
    op_reg = {7'd40,7'd120,7'd100};
    op_lin = {7'd3,7'd7,7'd1};
    rm_idx = {7'd20,7'd9,7'd27};
    @(negedge clk);
    chk(out_phys[7:0] == 8'd127 && out_ovr == 3'b000, "R8 last reg",
        {out_phys[7:0], out_ovr}, {8'd127, 3'b000});
    rm_idx = {7'd20,7'd9,7'd28};
    op_lin = {7'd3,7'd8,7'd1};
    @(negedge clk);
    chk(out_ovr == 3'b011, "R8 one past", out_ovr, 3'b011);
    op_vld = 3'b110;
    @(negedge clk);
    chk(out_ovr == 3'b010, "R8 invalid op", out_ovr, 3'b010);

    finish_run();
  end
endmodule